// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

A free-running 16-bit down-counter with two capture channels, A and B. Each channel watches its own input pin. When that pin shows the edge chosen for it, the live count is copied into the channel's capture register and the channel's pending flag is set. When the counter wraps from zero back to all-ones, a separate underflow pending flag is set.

The counter steps once for each cycle in which the tick-enable input is high, so a prescaler outside the block sets the time base. There is no start or stop control. Software programs the edge polarity and the interrupt enables through a small write port. It clears flags by writing ones to them and can preload the counter.

There is a single interrupt output. The underflow flag has no enable of its own and shares channel A's enable. An interrupt with enable A set can therefore mean an A capture, an underflow, or both.

Top module: `input_capture_timer`

## Requirements
- R1: The count steps down by one on every clock edge where `tick_en_i` is high, and holds where it is low. There is no stop control.
- R2: A tick taken while the count is 0 (with no counter write in that cycle) loads 0xFFFF and sets `uf_pend_o`.
- R3: Control register (address 0): bit 0 picks the edge for pin A and bit 1 picks the edge for pin B, where 0 means rising and 1 means falling. Bit 2 has no effect, so the value 3'b100 means rising on both pins. Bit 3 is enable A and bit 4 is enable B.
- R4: A qualifying edge on pin A loads only `cap_a_o`, and one on pin B loads only `cap_b_o`. The value loaded is the count that `count_o` shows in the cycle before the capture register changes. The load happens on the third rising clock edge after the pin changes, because the pin passes through two synchronizer flops and one edge-history flop.
- R5: An edge of the other polarity changes neither that channel's capture register nor its pending flag.
- R6: `pend_a_o`, `pend_b_o` and `uf_pend_o` stay set until software writes a 1 to address 1: bit 0 clears pending A, bit 1 clears pending B and bit 2 clears underflow.
- R7: If a clear and a new event hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` = ((pend A OR underflow) AND enable A) OR (pend B AND enable B).
- R9: After reset the count is 0xFFFF. The captures, flags, control bits and `irq_o` are all 0.
- R10: A write to address 2 loads the count from `reg_wdata_i`. It takes priority over a tick in the same cycle, and a load is never counted as an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Counter step enable (prescaled tick) |
| pin_a_i | input | 1 | Channel A trigger pin, asynchronous |
| pin_b_i | input | 1 | Channel B trigger pin, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 flag clear, 2 count |
| reg_wdata_i | input | 16 | Register write data |
| count_o | output | 16 | Live counter value |
| cap_a_o | output | 16 | Channel A capture register |
| cap_b_o | output | 16 | Channel B capture register |
| pend_a_o | output | 1 | Channel A pending flag |
| pend_b_o | output | 1 | Channel B pending flag |
| uf_pend_o | output | 1 | Underflow pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench checks the exact three-edge capture latency and which count value is captured. A design with one synchronizer flop too many or too few would capture a count one step off from the expected value. It lines up a flag clear with a fresh capture in the same cycle; a design that let the clear win would drop that event. It drives the wrap from 0 and a counter load that coincides with a tick, so a wrong wrap value, a missing underflow flag, or an underflow flagged on a load would all show. It drives edges of the ignored polarity and sets the underflow flag with only enable A on. A design that captured on both edges, or gated the underflow by enable B, would show up in the captures, the flags and `irq_o`.

// File: rtl/ict_pkg.sv
package ict_pkg;

    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CLR  = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    // control register field positions
    localparam int CTRL_POL_A = 0;
    localparam int CTRL_POL_B = 1;
    localparam int CTRL_EN_A  = 3;
    localparam int CTRL_EN_B  = 4;

    // clear register field positions
    localparam int CLR_A  = 0;
    localparam int CLR_B  = 1;
    localparam int CLR_UF = 2;

    localparam int NUM_CH = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic [NUM_CH-1:0] pol;
        logic              en_a;
        logic              en_b;
    } ctrl_t;

endpackage

// File: rtl/ict_sync_edge.sv
module ict_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    output logic hit_o
);
    import ict_pkg::*;

    localparam int MSB = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.sh   = STAGES'({sync_q.sh, pin_i});
        sync_d.prev = sync_q.sh[MSB];
        if (edge_pol_e'(pol_i) == EDGE_FALL) begin
            hit_o = sync_q.prev & ~sync_q.sh[MSB];
        end else begin
            hit_o = ~sync_q.prev & sync_q.sh[MSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // a held polarity never yields two hits in a row (R5: one edge, one event)
    assert_single_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (!hit_o || (pol_i != $past(pol_i))));

endmodule

// File: rtl/ict_counter.sv
module ict_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] count;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (load_i) begin
            cnt_d.count = load_val_i;
        end else if (tick_i) begin
            cnt_d.count = cnt_q.count - W'(1);
            wrap_o      = (cnt_q.count == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.count <= TOP;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.count;

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q.count));

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> (cnt_q.count == $past(cnt_q.count) - W'(1)));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q.count == TOP));

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q.count == $past(load_val_i)));

endmodule

// File: rtl/ict_channel.sv
module ict_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  logic         clr_i,
    input  logic [W-1:0] count_i,
    output logic [W-1:0] cap_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] cap;
        logic         pend;
    } chan_st_t;

    chan_st_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (hit_i) begin
            ch_d.cap = count_i;
        end
        // a new event outranks a clear in the same cycle
        ch_d.pend = hit_i | (ch_q.pend & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign cap_o  = ch_q.cap;
    assign pend_o = ch_q.pend;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> ch_q.pend);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.pend && !clr_i) |=> ch_q.pend);

    assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(ch_q.cap));

    assert_cap_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (ch_q.cap == $past(count_i)));

endmodule

// File: rtl/input_capture_timer.sv
module input_capture_timer
    import ict_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en_i,
    input  logic             pin_a_i,
    input  logic             pin_b_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cap_a_o,
    output logic [CNT_W-1:0] cap_b_o,
    output logic             pend_a_o,
    output logic             pend_b_o,
    output logic             uf_pend_o,
    output logic             irq_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  uf;
    } top_st_t;

    top_st_t top_d, top_q;

    logic [NUM_CH-1:0] pins;
    logic [NUM_CH-1:0] hits;
    logic [NUM_CH-1:0] ch_clr;
    logic [NUM_CH-1:0] ch_pend;
    logic [CNT_W-1:0]  ch_cap [NUM_CH];
    logic              cnt_load;
    logic              cnt_wrap;
    logic              clr_uf;
    logic              wr_ctrl;
    logic              wr_clr;

    assign pins = {pin_b_i, pin_a_i};

    always_comb begin
        wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
        wr_clr   = reg_we_i && (reg_addr_i == ADDR_CLR);
        cnt_load = reg_we_i && (reg_addr_i == ADDR_CNT);
        ch_clr   = '0;
        clr_uf   = 1'b0;
        if (wr_clr) begin
            ch_clr[0] = reg_wdata_i[CLR_A];
            ch_clr[1] = reg_wdata_i[CLR_B];
            clr_uf    = reg_wdata_i[CLR_UF];
        end

        top_d = top_q;
        if (wr_ctrl) begin
            top_d.ctrl.pol[0] = reg_wdata_i[CTRL_POL_A];
            top_d.ctrl.pol[1] = reg_wdata_i[CTRL_POL_B];
            top_d.ctrl.en_a   = reg_wdata_i[CTRL_EN_A];
            top_d.ctrl.en_b   = reg_wdata_i[CTRL_EN_B];
        end
        top_d.uf = cnt_wrap | (top_q.uf & ~clr_uf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    ict_counter #(.W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_en_i),
        .load_i    (cnt_load),
        .load_val_i(reg_wdata_i),
        .count_o   (count_o),
        .wrap_o    (cnt_wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ict_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_i(pins[g]),
            .pol_i(top_q.ctrl.pol[g]),
            .hit_o(hits[g])
        );

        ict_channel #(.W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (hits[g]),
            .clr_i  (ch_clr[g]),
            .count_i(count_o),
            .cap_o  (ch_cap[g]),
            .pend_o (ch_pend[g])
        );
    end

    assign cap_a_o   = ch_cap[0];
    assign cap_b_o   = ch_cap[1];
    assign pend_a_o  = ch_pend[0];
    assign pend_b_o  = ch_pend[1];
    assign uf_pend_o = top_q.uf;
    assign irq_o     = (top_q.ctrl.en_a & (ch_pend[0] | top_q.uf))
                     | (top_q.ctrl.en_b & ch_pend[1]);

    assert_uf_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wrap |=> uf_pend_o);

    assert_uf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_pend_o && !clr_uf) |=> uf_pend_o);

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_q.ctrl.en_a && !top_q.ctrl.en_b) |-> !irq_o);

    assert_irq_uf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.ctrl.en_a && uf_pend_o) |-> irq_o);

endmodule

// File: tb/input_capture_timer_tb_top.sv
module input_capture_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  pins = 2'b00;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;

    logic [15:0] count_o, cap_a_o, cap_b_o;
    logic        pend_a_o, pend_b_o, uf_pend_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    always #4 clk = ~clk;

    input_capture_timer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en_i  (tick_en),
        .pin_a_i    (pins[0]),
        .pin_b_i    (pins[1]),
        .reg_we_i   (we),
        .reg_addr_i (addr),
        .reg_wdata_i(wdata),
        .count_o    (count_o),
        .cap_a_o    (cap_a_o),
        .cap_b_o    (cap_b_o),
        .pend_a_o   (pend_a_o),
        .pend_b_o   (pend_b_o),
        .uf_pend_o  (uf_pend_o),
        .irq_o      (irq_o)
    );

    // reference model built from the requirements
    logic [15:0] m_cnt;
    logic [15:0] m_cap [2];
    logic [1:0]  m_pend, m_s1, m_s2, m_pv, m_pol;
    logic        m_uf, m_en_a, m_en_b;

    function automatic logic edge_f(input logic pol, input logic pv, input logic cur);
        return pol ? (pv & ~cur) : (~pv & cur);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 16'hFFFF; m_cap[0] <= '0; m_cap[1] <= '0;
            m_pend <= '0; m_s1 <= '0; m_s2 <= '0; m_pv <= '0;
            m_pol <= '0; m_uf <= 1'b0; m_en_a <= 1'b0; m_en_b <= 1'b0;
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                logic h;
                logic c;
                h = edge_f(m_pol[ch], m_pv[ch], m_s2[ch]);
                c = we && addr == 2'd1 && wdata[ch];
                if (h) m_cap[ch] <= m_cnt;
                m_pend[ch] <= h | (m_pend[ch] & ~c);
            end
            m_s1 <= pins; m_s2 <= m_s1; m_pv <= m_s2;
            if (we && addr == 2'd0) begin
                m_pol <= wdata[1:0]; m_en_a <= wdata[3]; m_en_b <= wdata[4];
            end
            if (we && addr == 2'd2) begin
                m_cnt <= wdata;
                m_uf  <= m_uf & ~(we && addr == 2'd1 && wdata[2]);
            end else if (tick_en) begin
                m_cnt <= m_cnt - 16'd1;
                m_uf  <= (m_cnt == 16'd0) | (m_uf & ~(we && addr == 2'd1 && wdata[2]));
            end else begin
                m_uf  <= m_uf & ~(we && addr == 2'd1 && wdata[2]);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R1 count", count_o, m_cnt);
        chk("R4 cap_a", cap_a_o, m_cap[0]);
        chk("R4 cap_b", cap_b_o, m_cap[1]);
        chk("R6 pend_a", {15'd0, pend_a_o}, {15'd0, m_pend[0]});
        chk("R6 pend_b", {15'd0, pend_b_o}, {15'd0, m_pend[1]});
        chk("R2 uf_pend", {15'd0, uf_pend_o}, {15'd0, m_uf});
        chk("R8 irq", {15'd0, irq_o},
            {15'd0, ((m_pend[0] | m_uf) & m_en_a) | (m_pend[1] & m_en_b)});
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
        we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        cyc();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] snap;
        void'($urandom(32'h1CAB5));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // R9 reset state
        chk("R9 count", count_o, 16'hFFFF);
        chk("R9 cap_a", cap_a_o, 16'h0);
        chk("R9 flags+irq", {12'd0, pend_a_o, pend_b_o, uf_pend_o, irq_o}, 16'h0);

        // R3 rising on both pins, both enables (ctrl = 3'b100, en bits 3,4)
        wr(2'd0, 16'h001C);
        tick_en = 1'b1;
        pins[0] = 1'b1;
        cyc(); cyc();
        snap = count_o;
        cyc();
        chk("R4 cap_a latency", cap_a_o, snap);
        chk("R3 pend_a rising", {15'd0, pend_a_o}, 16'd1);
        chk("R4 cap_b untouched", cap_b_o, 16'h0);

        // R5 channel B set to falling: rising edge ignored
        wr(2'd0, 16'h001A);
        pins[1] = 1'b1;
        repeat (5) cyc();
        chk("R5 pend_b after wrong edge", {15'd0, pend_b_o}, 16'd0);
        chk("R5 cap_b after wrong edge", cap_b_o, 16'h0);
        pins[1] = 1'b0;
        cyc(); cyc();
        snap = count_o;
        cyc();
        chk("R3 cap_b falling", cap_b_o, snap);
        chk("R8 irq from B", {15'd0, irq_o}, 16'd1);

        // R7 clear coincides with a new A event (A now rising, pol bit 0 = 0)
        pins[0] = 1'b0; repeat (4) cyc();
        pins[0] = 1'b1;
        cyc(); cyc();
        we = 1'b1; addr = 2'd1; wdata = 16'h0001;
        cyc();
        chk("R7 set wins", {15'd0, pend_a_o}, 16'd1);

        // R6 clear all flags
        wr(2'd1, 16'h0007);
        chk("R6 cleared", {13'd0, pend_a_o, pend_b_o, uf_pend_o}, 16'h0);

        // R10 load, R2 wrap
        tick_en = 1'b0;
        wr(2'd2, 16'd2);
        chk("R10 load", count_o, 16'd2);
        tick_en = 1'b1;
        cyc(); cyc();
        chk("R1 step to zero", count_o, 16'd0);
        chk("R2 no uf yet", {15'd0, uf_pend_o}, 16'd0);
        cyc();
        chk("R2 wrap value", count_o, 16'hFFFF);
        chk("R2 uf set", {15'd0, uf_pend_o}, 16'd1);
        wr(2'd0, 16'h0008);
        chk("R8 uf irq via en A", {15'd0, irq_o}, 16'd1);
        wr(2'd1, 16'h0004);
        tick_en = 1'b0;
        wr(2'd2, 16'd0);
        tick_en = 1'b1;
        wr(2'd2, 16'h1234);
        chk("R10 load beats tick", count_o, 16'h1234);
        chk("R10 no uf on load", {15'd0, uf_pend_o}, 16'd0);
        tick_en = 1'b0;
        cyc();
        chk("R1 hold", count_o, 16'h1234);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            tick_en = ($urandom_range(3) != 0);
            if ($urandom_range(7) == 0) pins[0] = ~pins[0];
            if ($urandom_range(7) == 0) pins[1] = ~pins[1];
            if ($urandom_range(9) == 0) begin
                we = 1'b1;
                addr = 2'($urandom_range(3));
                wdata = (addr == 2'd2 && $urandom_range(1) == 0) ? 16'd3 : 16'($urandom());
            end
            cyc();
        end

        summary();
        $finish;
    end

endmodule